// File: doc/BRIEF.md
# Multi-lane link test pattern generator

This block produces the per-lane symbol bit stream of a link layer with up to four lanes, one bit per lane per clock. In normal operation each lane passes its incoming data bit straight to the output. For link bring-up and compliance work, a global mode field can force every active lane onto one of two fixed training sequences. A third mode hands each lane to its own pattern source: a pseudo-random bit sequence of selectable order, a 264-bit programmable pattern, a square wave of programmable half period, or either training sequence.

Software programs the block through a simple write-only configuration port. The port carries an enable bit, the mode, the number of active lanes, the per-lane source and PRBS selections, the square-wave width and eleven 24-bit words that hold the custom pattern. Generator state restarts only on events that change what a lane is meant to send. Rewriting an unchanged configuration leaves the running sequences undisturbed.

Top module: `link_tp_gen`

## Requirements
- R1: After reset the link is disabled and every lane output is 0.
- R2: Register 0 holds enable at bit 0, mode at bits [2:1] and lane count at bits [5:4]; while enable is 0 every lane output is 0 and the generators hold their state.
- R3: Lane count encoding 0 activates lane 0 only, 1 and 2 activate lanes 0 and 1, and 3 activates all four lanes; inactive lanes output 0.
- R4: Mode 0 passes vid_i[n] to lane_o[n] on every active lane in the same cycle.
- R5: Mode 1 drives training pattern TPS1_PAT and mode 2 drives TPS2_PAT on every active lane, ignoring the per-lane source. The 8-bit constant is sent MSB first and repeats, and it starts at bit 7 after a restart.
- R6: Mode 3 uses the per-lane source in register 1, lane n at bits [3n+2:3n]: 0 PRBS, 1 TPS1, 2 TPS2, 3 custom, 4 square.
- R7: The PRBS selector in register 2, lane n at bits [3n+2:3n], picks order 7, 9, 11, 15, 23 or 31 for codes 0 to 5, with code 6 and code 7 acting as code 0. The polynomials are x^7+x^6+1, x^9+x^5+1, x^11+x^9+1, x^15+x^14+1, x^23+x^18+1 and x^31+x^28+1. For order a and tap b the state s is seeded to all ones. The output is s[a-1], and each cycle s shifts left with s[a-1]^s[b-1] entering bit 0.
- R8: Registers 4 to 14 hold custom words 0 to 10 in bits [23:0]. Word w carries pattern byte 3w in bits [7:0], byte 3w+1 in bits [15:8] and byte 3w+2 in bits [23:16]. The lane sends pattern bit k (bit k%8 of byte k/8) for k = 0 to 263 and then wraps to bit 0.
- R9: Register 3 bits [7:0] give width W. The square source outputs 1 for W cycles and then 0 for W cycles, starting high after a restart, and a width of 0 acts as 1.
- R10: A lane restarts its generators when enable goes from 0 to 1, when the mode field changes, or when its own source or PRBS code changes. Writing register 0 with enable already 1 and the mode unchanged does not restart anything.
- R11: In mode 3, a source code of 5, 6 or 7 drives 0 on that lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 5 | Configuration register address |
| cfg_wdata_i | input | 32 | Configuration write data |
| vid_i | input | 4 | Pass-through data bit per lane |
| lane_o | output | 4 | Output bit per lane |

## Verification
The custom pattern is checked across the wrap from bit 263 to bit 0 on bytes built to reveal the byte order and the bit order inside each word. A swapped packing or an off-by-one length shows up as a mismatch inside the first 300 bits. Each PRBS order runs for a hundred bits against a bench model of its recurrence, so a wrong tap or a wrong seed is caught within a few bits. The bench rewrites an unchanged control word in the middle of a PRBS run and changes one lane's PRBS code. A design that restarts on every write would show a sequence break on all lanes, and one that ignores selector changes would keep the old sequence on the reprogrammed lane. The bench also covers a square width of zero, lane count code 2, and an invalid source code. A design that divides by zero would stick at one level, and a design without that source decode would leak some other pattern onto the lane.

// File: rtl/link_tp_pkg.sv
package link_tp_pkg;
  localparam logic [1:0] MODE_VIDEO = 2'd0;
  localparam logic [1:0] MODE_TPS1  = 2'd1;
  localparam logic [1:0] MODE_TPS2  = 2'd2;
  localparam logic [1:0] MODE_TEST  = 2'd3;

  localparam logic [2:0] SRC_PRBS   = 3'd0;
  localparam logic [2:0] SRC_TPS1   = 3'd1;
  localparam logic [2:0] SRC_TPS2   = 3'd2;
  localparam logic [2:0] SRC_CUSTOM = 3'd3;
  localparam logic [2:0] SRC_SQUARE = 3'd4;

  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_SRC   = 1;
  localparam int ADDR_PRBS  = 2;
  localparam int ADDR_WIDTH = 3;
  localparam int ADDR_CUST0 = 4;

  localparam int SEL_W = 3;
endpackage

// File: rtl/link_tp_cfg.sv
module link_tp_cfg
  import link_tp_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int CUST_WORDS = 11,
  parameter int WORD_W     = 24,
  parameter int PW_W       = 8,
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 32,
  localparam int CUST_BITS = CUST_WORDS * WORD_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic                       en_o,
  output logic [1:0]                 mode_o,
  output logic [1:0]                 lane_cnt_o,
  output logic [NUM_LANES*SEL_W-1:0] src_o,
  output logic [NUM_LANES*SEL_W-1:0] prbs_o,
  output logic [PW_W-1:0]            width_o,
  output logic [CUST_BITS-1:0]       custom_o,
  output logic [NUM_LANES-1:0]       restart_o
);
  logic ctrl_wr, src_wr, prbs_wr, en_rise, mode_chg;

  assign ctrl_wr  = we_i && (addr_i == ADDR_W'(ADDR_CTRL));
  assign src_wr   = we_i && (addr_i == ADDR_W'(ADDR_SRC));
  assign prbs_wr  = we_i && (addr_i == ADDR_W'(ADDR_PRBS));
  assign en_rise  = ctrl_wr && wdata_i[0] && !en_o;
  assign mode_chg = ctrl_wr && (wdata_i[2:1] != mode_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o       <= 1'b0;
      mode_o     <= MODE_VIDEO;
      lane_cnt_o <= 2'd0;
      src_o      <= '0;
      prbs_o     <= '0;
      width_o    <= '0;
      custom_o   <= '0;
    end else if (we_i) begin
      if (ctrl_wr) begin
        en_o       <= wdata_i[0];
        mode_o     <= wdata_i[2:1];
        lane_cnt_o <= wdata_i[5:4];
      end
      if (src_wr)  src_o  <= wdata_i[NUM_LANES*SEL_W-1:0];
      if (prbs_wr) prbs_o <= wdata_i[NUM_LANES*SEL_W-1:0];
      if (addr_i == ADDR_W'(ADDR_WIDTH)) width_o <= wdata_i[PW_W-1:0];
      for (int w = 0; w < CUST_WORDS; w++) begin
        if (addr_i == ADDR_W'(ADDR_CUST0 + w))
          custom_o[w*WORD_W +: WORD_W] <= wdata_i[WORD_W-1:0];
      end
    end
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_rst
    logic src_chg, prbs_chg;
    assign src_chg  = src_wr  && (wdata_i[l*SEL_W +: SEL_W] != src_o[l*SEL_W +: SEL_W]);
    assign prbs_chg = prbs_wr && (wdata_i[l*SEL_W +: SEL_W] != prbs_o[l*SEL_W +: SEL_W]);
    assign restart_o[l] = en_rise || mode_chg || src_chg || prbs_chg;
  end
endmodule

// File: rtl/link_tp_prbs.sv
module link_tp_prbs
  import link_tp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seed_i,
  input  logic             adv_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             bit_o
);
  localparam int SR_W = 31;

  logic [SR_W-1:0] sr_q, live_mask;
  logic [4:0]      ord_m1, tap_m1;

  always_comb begin
    case (sel_i)
      3'd1:    begin ord_m1 = 5'd8;  tap_m1 = 5'd4;  end
      3'd2:    begin ord_m1 = 5'd10; tap_m1 = 5'd8;  end
      3'd3:    begin ord_m1 = 5'd14; tap_m1 = 5'd13; end
      3'd4:    begin ord_m1 = 5'd22; tap_m1 = 5'd17; end
      3'd5:    begin ord_m1 = 5'd30; tap_m1 = 5'd27; end
      default: begin ord_m1 = 5'd6;  tap_m1 = 5'd5;  end
    endcase
    live_mask = (SR_W'(1) << (ord_m1 + 5'd1)) - SR_W'(1);
  end

  assign bit_o = sr_q[ord_m1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '1;
    else if (seed_i) sr_q <= '1;
    else if (adv_i)  sr_q <= {sr_q[SR_W-2:0], sr_q[ord_m1] ^ sr_q[tap_m1]};
  end

  AST_PRBS_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_q & live_mask) != '0); // R7
endmodule

// File: rtl/link_tp_lane.sv
module link_tp_lane
  import link_tp_pkg::*;
#(
  parameter int          PW_W      = 8,
  parameter int          CUST_BITS = 264,
  parameter logic [7:0]  TPS1_PAT  = 8'hB4,
  parameter logic [7:0]  TPS2_PAT  = 8'h6C,
  localparam int         CIDX_W    = $clog2(CUST_BITS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 restart_i,
  input  logic                 en_i,
  input  logic                 active_i,
  input  logic [1:0]           mode_i,
  input  logic [SEL_W-1:0]     src_i,
  input  logic [SEL_W-1:0]     prbs_sel_i,
  input  logic                 vid_i,
  input  logic [PW_W-1:0]      width_i,
  input  logic [CUST_BITS-1:0] custom_i,
  output logic                 bit_o
);
  localparam logic [CIDX_W-1:0] CIDX_LAST = CIDX_W'(CUST_BITS - 1);

  logic              adv, prbs_bit, sq_lvl_q, sel_bit;
  logic [2:0]        tps_idx_q;
  logic [CIDX_W-1:0] cidx_q;
  logic [PW_W-1:0]   sq_cnt_q;
  logic [PW_W:0]     sq_eff;

  assign adv    = en_i && !restart_i;
  assign sq_eff = (width_i == '0) ? (PW_W+1)'(1) : {1'b0, width_i};

  link_tp_prbs u_prbs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .seed_i (restart_i),
    .adv_i  (adv),
    .sel_i  (prbs_sel_i),
    .bit_o  (prbs_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || restart_i) ;
    if (!rst_ni) begin
      tps_idx_q <= '0;
      cidx_q    <= '0;
      sq_cnt_q  <= '0;
      sq_lvl_q  <= 1'b1;
    end else if (restart_i) begin
      tps_idx_q <= '0;
      cidx_q    <= '0;
      sq_cnt_q  <= '0;
      sq_lvl_q  <= 1'b1;
    end else if (adv) begin
      tps_idx_q <= tps_idx_q + 3'd1;
      cidx_q    <= (cidx_q == CIDX_LAST) ? '0 : cidx_q + CIDX_W'(1);
      if (({1'b0, sq_cnt_q} + (PW_W+1)'(1)) >= sq_eff) begin
        sq_cnt_q <= '0;
        sq_lvl_q <= ~sq_lvl_q;
      end else begin
        sq_cnt_q <= sq_cnt_q + PW_W'(1);
      end
    end
  end

  always_comb begin
    sel_bit = 1'b0;
    case (mode_i)
      MODE_VIDEO: sel_bit = vid_i;
      MODE_TPS1:  sel_bit = TPS1_PAT[~tps_idx_q];
      MODE_TPS2:  sel_bit = TPS2_PAT[~tps_idx_q];
      default: begin
        case (src_i)
          SRC_PRBS:   sel_bit = prbs_bit;
          SRC_TPS1:   sel_bit = TPS1_PAT[~tps_idx_q];
          SRC_TPS2:   sel_bit = TPS2_PAT[~tps_idx_q];
          SRC_CUSTOM: sel_bit = custom_i[cidx_q];
          SRC_SQUARE: sel_bit = sq_lvl_q;
          default:    sel_bit = 1'b0;
        endcase
      end
    endcase
  end

  assign bit_o = en_i && active_i && sel_bit;

  AST_CUST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && cidx_q == CIDX_LAST) |=> (cidx_q == '0)); // R8
endmodule

// File: rtl/link_tp_gen.sv
module link_tp_gen
  import link_tp_pkg::*;
#(
  parameter int         NUM_LANES  = 4,
  parameter int         CUST_WORDS = 11,
  parameter int         WORD_W     = 24,
  parameter int         PW_W       = 8,
  parameter logic [7:0] TPS1_PAT   = 8'hB4,
  parameter logic [7:0] TPS2_PAT   = 8'h6C,
  localparam int        ADDR_W     = 5,
  localparam int        DATA_W     = 32,
  localparam int        CUST_BITS  = CUST_WORDS * WORD_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [ADDR_W-1:0]    cfg_addr_i,
  input  logic [DATA_W-1:0]    cfg_wdata_i,
  input  logic [NUM_LANES-1:0] vid_i,
  output logic [NUM_LANES-1:0] lane_o
);
  logic                       en;
  logic [1:0]                 mode, lane_cnt;
  logic [NUM_LANES*SEL_W-1:0] src, prbs;
  logic [PW_W-1:0]            width;
  logic [CUST_BITS-1:0]       custom;
  logic [NUM_LANES-1:0]       restart;
  int unsigned                n_active;

  link_tp_cfg #(
    .NUM_LANES  (NUM_LANES),
    .CUST_WORDS (CUST_WORDS),
    .WORD_W     (WORD_W),
    .PW_W       (PW_W),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .en_o       (en),
    .mode_o     (mode),
    .lane_cnt_o (lane_cnt),
    .src_o      (src),
    .prbs_o     (prbs),
    .width_o    (width),
    .custom_o   (custom),
    .restart_o  (restart)
  );

  always_comb begin
    case (lane_cnt)
      2'd0:    n_active = 1;
      2'd3:    n_active = 4;
      default: n_active = 2;
    endcase
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    link_tp_lane #(
      .PW_W      (PW_W),
      .CUST_BITS (CUST_BITS),
      .TPS1_PAT  (TPS1_PAT),
      .TPS2_PAT  (TPS2_PAT)
    ) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .restart_i  (restart[l]),
      .en_i       (en),
      .active_i   (l < n_active),
      .mode_i     (mode),
      .src_i      (src[l*SEL_W +: SEL_W]),
      .prbs_sel_i (prbs[l*SEL_W +: SEL_W]),
      .vid_i      (vid_i[l]),
      .width_i    (width),
      .custom_i   (custom),
      .bit_o      (lane_o[l])
    );
  end

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == ADDR_W'(ADDR_CTRL) && !cfg_wdata_i[0]) |=> (lane_o == '0)); // R2
  AST_ONE_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_cnt == 2'd0) |-> (lane_o[NUM_LANES-1:1] == '0)); // R3
  AST_VIDEO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && mode == MODE_VIDEO && lane_cnt == 2'd3) |-> (lane_o == vid_i)); // R4
endmodule

// File: tb/link_tp_gen_bench.sv
module link_tp_gen_bench;
  localparam int         CLK_PERIOD = 10;
  localparam logic [7:0] T1 = 8'hB4;
  localparam logic [7:0] T2 = 8'h6C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  vid = '0;
  logic [3:0]  lane;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [30:0]  ps [4];
  int           psel [4];
  int           kcnt [4];
  logic [11:0]  src_w, prbs_w;
  int           wid;
  logic [7:0]   bytes_a [33];
  logic [263:0] cvec;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_tp_gen #(.TPS1_PAT(T1), .TPS2_PAT(T2)) u_link_tp_gen (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .vid_i(vid), .lane_o(lane)
  );

  function automatic logic [31:0] ctl(bit en, logic [1:0] md, logic [1:0] lc);
    return {26'd0, lc, 1'b0, md, en};
  endfunction

  function automatic void ord_tap(int sel, output int a, output int b);
    case (sel)
      1: begin a = 9;  b = 5;  end
      2: begin a = 11; b = 9;  end
      3: begin a = 15; b = 14; end
      4: begin a = 23; b = 18; end
      5: begin a = 31; b = 28; end
      default: begin a = 7; b = 6; end
    endcase
  endfunction

  function automatic logic exp_lane(int i);
    int a, b, w;
    logic [2:0] s;
    s = src_w[3*i +: 3];
    ord_tap(psel[i], a, b);
    w = (wid == 0) ? 1 : wid;
    case (s)
      3'd0: return ps[i][a-1];
      3'd1: return T1[7 - (kcnt[i] % 8)];
      3'd2: return T2[7 - (kcnt[i] % 8)];
      3'd3: return cvec[kcnt[i] % 264];
      3'd4: return ((kcnt[i] / w) % 2) == 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    we = 1'b1; addr = a[4:0]; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic step_lane(int i);
    int a, b;
    ord_tap(psel[i], a, b);
    ps[i] = {ps[i][29:0], ps[i][a-1] ^ ps[i][b-1]};
    kcnt[i]++;
  endtask

  task automatic seed_lane(int i);
    ps[i] = '1; kcnt[i] = 0; psel[i] = int'(prbs_w[3*i +: 3]);
  endtask

  task automatic run(input int n, input string req);
    for (int c = 0; c < n; c++) begin
      logic [3:0] e;
      for (int i = 0; i < 4; i++) e[i] = exp_lane(i);
      chk(lane, e, req);
      for (int i = 0; i < 4; i++) step_lane(i);
      @(negedge clk);
    end
  endtask

  task automatic arm(input logic [11:0] s, input logic [11:0] p, input int w);
    src_w = s; prbs_w = p; wid = w;
    wr(0, ctl(0, 2'd3, 2'd3));
    wr(1, {20'd0, s});
    wr(2, {20'd0, p});
    wr(3, w);
    wr(0, ctl(1, 2'd3, 2'd3));
    for (int i = 0; i < 4; i++) seed_lane(i);
  endtask

  task automatic t_reset;
    chk(lane, 4'h0, "R1 reset outputs");
    vid = 4'hF; #1;
    chk(lane, 4'h0, "R1 disabled after reset");
    vid = 4'h0;
  endtask

  task automatic t_disabled;
    wr(0, ctl(0, 2'd0, 2'd3));
    vid = 4'hF;
    for (int c = 0; c < 4; c++) begin
      #1; chk(lane, 4'h0, "R2 disabled quiet");
      @(negedge clk);
    end
  endtask

  task automatic t_video;
    wr(0, ctl(1, 2'd0, 2'd3));
    for (int c = 0; c < 16; c++) begin
      vid = 4'(c * 7 + 3); #1;
      chk(lane, vid, "R4 video pass");
      @(negedge clk);
    end
  endtask

  task automatic t_lanecnt;
    vid = 4'hF;
    wr(0, ctl(1, 2'd0, 2'd0)); #1; chk(lane, 4'b0001, "R3 one lane");
    wr(0, ctl(1, 2'd0, 2'd1)); #1; chk(lane, 4'b0011, "R3 two lanes");
    wr(0, ctl(1, 2'd0, 2'd2)); #1; chk(lane, 4'b0011, "R3 code 2");
    wr(0, ctl(1, 2'd0, 2'd3)); #1; chk(lane, 4'b1111, "R3 four lanes");
    vid = 4'h0;
  endtask

  task automatic t_train;
    wr(1, 32'hFFF);
    wr(0, ctl(1, 2'd1, 2'd3));
    for (int c = 0; c < 16; c++) begin
      chk(lane, {4{T1[7 - c % 8]}}, "R5 TPS1 mode");
      @(negedge clk);
    end
    wr(0, ctl(1, 2'd2, 2'd1));
    for (int c = 0; c < 16; c++) begin
      chk(lane, {2'b00, {2{T2[7 - c % 8]}}}, "R5 TPS2 mode");
      @(negedge clk);
    end
  endtask

  task automatic t_prbs;
    arm(12'h000, {3'd3, 3'd2, 3'd1, 3'd0}, 1);
    run(100, "R7 PRBS 7/9/11/15");
    arm(12'h000, {3'd6, 3'd5, 3'd5, 3'd4}, 1);
    run(100, "R7 PRBS 23/31");
  endtask

  task automatic t_custom;
    for (int b = 0; b < 33; b++) begin
      bytes_a[b] = 8'((b * 37 + 11) ^ (b << 5));
      cvec[8*b +: 8] = bytes_a[b];
    end
    for (int w = 0; w < 11; w++)
      wr(4 + w, {8'd0, bytes_a[3*w+2], bytes_a[3*w+1], bytes_a[3*w]});
    arm({3'd7, 3'd2, 3'd3, 3'd3}, 12'h000, 2);
    run(300, "R8 R11 R6 custom/invalid/tps2");
  endtask

  task automatic t_square;
    arm({3'd4, 3'd4, 3'd4, 3'd1}, 12'h000, 3);
    run(20, "R9 R6 square width 3");
    arm({3'd4, 3'd4, 3'd4, 3'd4}, 12'h000, 0);
    run(10, "R9 square width 0");
  endtask

  task automatic t_restart;
    arm(12'h000, 12'h000, 1);
    run(10, "R10 pre");
    wr(0, ctl(1, 2'd3, 2'd3));
    for (int i = 0; i < 4; i++) step_lane(i);
    run(20, "R10 rewrite keeps run");
    prbs_w = 12'h008;
    wr(2, {20'd0, prbs_w});
    step_lane(0); step_lane(2); step_lane(3);
    seed_lane(1);
    run(30, "R10 lane reselect");
    wr(0, ctl(0, 2'd3, 2'd3));
    chk(lane, 4'h0, "R2 disable");
    wr(0, ctl(1, 2'd3, 2'd3));
    for (int i = 0; i < 4; i++) seed_lane(i);
    run(20, "R10 enable restart");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_disabled();
    t_video();
    t_lanecnt();
    t_train();
    t_prbs();
    t_custom();
    t_square();
    t_restart();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule